// File: doc/BRIEF.md
# Multi-Clock Frequency Meter

This block measures the frequency of several free-running clocks that are asynchronous to each other and to a reference clock. The reference clock also runs the register port. Software first clears the results. It then sets the start bit and polls the busy bit until it drops, and finally reads one count per measured clock.

A measurement holds a gate open for a fixed number of reference cycles. While the gate is open, each measured clock counts its own rising edges. A count therefore equals the measured frequency times the window length divided by the reference frequency. With the default window of 10000 cycles and a 100 MHz reference, a count divided by 100 gives the frequency in MHz.

A three-state controller runs the measurement, with states IDLE, COUNT and DRAIN:
- IDLE goes to COUNT when a start is accepted.
- COUNT goes to DRAIN when the window closes.
- DRAIN goes to IDLE after a fixed settling time. At that moment every frozen count is copied into the register domain.
- A clear sends COUNT or DRAIN straight back to IDLE.

The gate and a start marker reach each measured clock through two-flop synchronizers. Each measured clock keeps its own saturating counter.

Top module: `freq_meter`

## Requirements
- R1: After reset, busy reads 0, and the reference count and every clock count read 0.
- R2: Control sits at offset 0x00. A write with bit 0 = 1 and bit 31 = 0 while idle starts a measurement. Busy (control bit 0) then reads 1 from the cycle after the write for exactly WINDOW + DRAIN_CYC reference cycles, and 0 afterwards. Control bit 31 and all other control bits read 0.
- R3: The window lasts WINDOW reference cycles. The reference count at offset 0x04 reads k after the k-th cycle of the window and reads WINDOW once the measurement ends.
- R4: After busy falls, clock i's count at offset 0x10 + 4*i equals its frequency times WINDOW divided by the reference frequency, within the count of 1 MHz.
- R5: A start written while busy is ignored: the window is not restarted and busy falls at its original time.
- R6: A write to control with bit 31 = 1 clears the reference count and all clock counts and aborts any measurement, so busy reads 0 in the next cycle. Bit 31 wins over bit 0 in the same write.
- R7: A clock count saturates at 2^CNT_W - 1 instead of wrapping.
- R8: Clock counts hold their value after busy falls until the next clear or accepted start. An accepted start makes them read 0 until the new result is captured.
- R9: Reads of unmapped offsets (for example 0x08 and 0x38) return 0. Writes to any offset other than 0x00 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Active-low reset |
| meas_clk | input | N_CLK | Clocks under measurement, one bit per lane |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
The bench builds the block with a 250 MHz reference, WINDOW = 2500, DRAIN_CYC = 32 and CNT_W = 12, so one count is 0.1 MHz and a full measurement takes about 2.5k cycles. That lets it run several measurements with randomly drawn clock periods, plus directed checks of exact busy timing and of the ignored start. The narrow 12-bit counter lets a 500 MHz lane reach the saturation value of 4095. A 20 ns clock stays within the settling time, which exercises the DRAIN state for the slowest lanes.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DRAIN = 2'd2
    } meter_state_t;

    localparam int CTRL_OFS  = 'h00;
    localparam int REFC_OFS  = 'h04;
    localparam int LANE_BASE = 'h10;
    localparam int LANE_STEP = 4;
    localparam int GO_BIT    = 0;
    localparam int WIPE_BIT  = 31;

endpackage

// File: rtl/freq_meter_window.sv
module freq_meter_window
    import freq_meter_pkg::*;
#(
    parameter int WINDOW    = 10000,
    parameter int DRAIN_CYC = 16,
    parameter int REF_W     = $clog2(WINDOW + 1),
    parameter int DRN_W     = $clog2(DRAIN_CYC + 1)
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             clear_req,
    output meter_state_t     state,
    output logic             run,
    output logic             busy,
    output logic             launch,
    output logic             capture,
    output logic             gen,
    output logic [REF_W-1:0] ref_cnt
);

    meter_state_t     state_q, state_d;
    logic [DRN_W-1:0] drn_q;
    logic             window_end, drain_end;

    assign window_end = (ref_cnt == REF_W'(WINDOW - 1));
    assign drain_end  = (drn_q == DRN_W'(DRAIN_CYC - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req && !clear_req) state_d = ST_COUNT;
            ST_COUNT: if (clear_req) state_d = ST_IDLE;
                      else if (window_end) state_d = ST_DRAIN;
            ST_DRAIN: if (clear_req || drain_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register (gate registered for the crossing)
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run     <= 1'b0;
        end else begin
            state_q <= state_d;
            run     <= (state_d == ST_COUNT);
        end
    end

    // window, drain and start-marker counters
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            drn_q   <= '0;
            gen     <= 1'b0;
        end else begin
            if (clear_req || launch)       ref_cnt <= '0;
            else if (state_q == ST_COUNT)  ref_cnt <= ref_cnt + 1'b1;
            drn_q <= (state_q == ST_DRAIN) ? drn_q + 1'b1 : '0;
            if (launch) gen <= ~gen;
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        busy    = (state_q != ST_IDLE);
        launch  = (state_q == ST_IDLE) && start_req && !clear_req;
        capture = (state_q == ST_DRAIN) && drain_end && !clear_req;
    end

endmodule

// File: rtl/freq_meter_lane.sv
module freq_meter_lane #(
    parameter int CNT_W = 32
) (
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gen,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [1:0] run_s, gen_s;
    logic       gen_seen;

    always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n) begin
            run_s    <= '0;
            gen_s    <= '0;
            gen_seen <= 1'b0;
            cnt      <= '0;
        end else begin
            run_s    <= {run_s[0], run};
            gen_s    <= {gen_s[0], gen};
            gen_seen <= gen_s[1];
            if (gen_s[1] != gen_seen)               cnt <= '0;
            else if (run_s[1] && cnt != CNT_MAX)    cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/freq_meter_regs.sv
module freq_meter_regs
    import freq_meter_pkg::*;
#(
    parameter int N_CLK  = 10,
    parameter int CNT_W  = 32,
    parameter int REF_W  = 14,
    parameter int ADDR_W = 8
) (
    input  logic                        ref_clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        start_req,
    output logic                        clear_req,
    input  logic                        busy,
    input  logic                        launch,
    input  logic                        capture,
    input  logic [REF_W-1:0]            ref_cnt,
    input  logic [N_CLK-1:0][CNT_W-1:0] lane_cnt,
    output logic [N_CLK-1:0][CNT_W-1:0] shadow
);

    logic ctrl_hit;
    logic unused_wdata;

    assign ctrl_hit     = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
    assign start_req    = ctrl_hit && reg_wdata[GO_BIT];
    assign clear_req    = ctrl_hit && reg_wdata[WIPE_BIT];
    assign unused_wdata = ^reg_wdata[WIPE_BIT-1:GO_BIT+1];

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                   shadow <= '0;
        else if (clear_req || launch) shadow <= '0;
        else if (capture)             shadow <= lane_cnt;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTRL_OFS))      reg_rdata[GO_BIT] = busy;
        else if (reg_addr == ADDR_W'(REFC_OFS)) reg_rdata = 32'(ref_cnt);
        for (int i = 0; i < N_CLK; i++) begin
            if (reg_addr == ADDR_W'(LANE_BASE + LANE_STEP * i))
                reg_rdata = 32'(shadow[i]);
        end
    end

endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import freq_meter_pkg::*;
#(
    parameter int N_CLK     = 10,
    parameter int WINDOW    = 10000,
    parameter int DRAIN_CYC = 16,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 8
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [N_CLK-1:0]  meas_clk,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam int REF_W = $clog2(WINDOW + 1);

    meter_state_t               state;
    logic                       run, busy, launch, capture, gen;
    logic                       start_req, clear_req;
    logic [REF_W-1:0]           ref_cnt;
    logic [N_CLK-1:0][CNT_W-1:0] lane_cnt;
    logic [N_CLK-1:0][CNT_W-1:0] shadow_flat;

    freq_meter_window #(.WINDOW(WINDOW), .DRAIN_CYC(DRAIN_CYC), .REF_W(REF_W)) u_window (
        .ref_clk(ref_clk), .rst_n(rst_n), .start_req(start_req), .clear_req(clear_req),
        .state(state), .run(run), .busy(busy), .launch(launch), .capture(capture),
        .gen(gen), .ref_cnt(ref_cnt)
    );

    for (genvar g = 0; g < N_CLK; g++) begin : g_lane
        freq_meter_lane #(.CNT_W(CNT_W)) u_lane (
            .meas_clk(meas_clk[g]), .rst_n(rst_n), .run(run), .gen(gen),
            .cnt(lane_cnt[g])
        );
    end

    freq_meter_regs #(.N_CLK(N_CLK), .CNT_W(CNT_W), .REF_W(REF_W), .ADDR_W(ADDR_W)) u_regs (
        .ref_clk(ref_clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_req(start_req),
        .clear_req(clear_req), .busy(busy), .launch(launch), .capture(capture),
        .ref_cnt(ref_cnt), .lane_cnt(lane_cnt), .shadow(shadow_flat)
    );

endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk
    import freq_meter_pkg::*;
#(
    parameter int N_CLK  = 10,
    parameter int WINDOW = 10000,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int REF_W  = 14
) (
    input logic                        ref_clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [31:0]                 reg_wdata,
    input logic                        busy,
    input meter_state_t                state,
    input logic [REF_W-1:0]            ref_cnt,
    input logic [N_CLK-1:0][CNT_W-1:0] shadow_flat
);

    logic ctrl_wr;
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));

    // R2: accepted start raises busy with a fresh window
    a_r2_start_raises_busy: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!busy && ctrl_wr && reg_wdata[0] && !reg_wdata[31]) |=> (busy && ref_cnt == '0));

    // R3: window closes after exactly WINDOW reference cycles
    a_r3_window_length: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_DRAIN && $past(state) == ST_COUNT) |-> (ref_cnt == REF_W'(WINDOW)));

    // R5: a start while counting does not restart the window
    a_r5_busy_start_ignored: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_COUNT && ctrl_wr && reg_wdata[0] && !reg_wdata[31]) |=> (ref_cnt != '0));

    // R6: clear aborts and wipes everything
    a_r6_clear_aborts: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[31]) |=> (!busy && ref_cnt == '0 && shadow_flat == '0));

    // R8: results hold while idle and untouched
    a_r8_counts_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!busy && !ctrl_wr) |=> $stable(shadow_flat));

endmodule

bind freq_meter freq_meter_chk #(
    .N_CLK(N_CLK), .WINDOW(WINDOW), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REF_W(REF_W)
) u_chk (
    .ref_clk(ref_clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .state(state), .ref_cnt(ref_cnt),
    .shadow_flat(shadow_flat)
);

// File: tb/test_freq_meter.sv
module test_freq_meter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_CLK     = 10;
    localparam int WINDOW    = 2500;
    localparam int DRAIN_CYC = 32;
    localparam int CNT_W     = 12;
    localparam int ADDR_W    = 8;
    localparam int REF_PS    = 4000;              // 250 MHz
    localparam int CNT_MAX   = (1 << CNT_W) - 1;
    localparam int TOL       = WINDOW * REF_PS / 1000000;   // counts per MHz

    logic              ref_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CLK-1:0]  meas_clk;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    int unsigned       hp_ps [N_CLK];
    int                n_checks = 0, n_fail = 0;
    bit                done = 1'b0;

    always #2 ref_clk = ~ref_clk;

    for (genvar g = 0; g < N_CLK; g++) begin : g_clk
        logic c = 1'b0;
        initial forever #(real'(hp_ps[g]) / 1000.0) c = ~c;
        assign meas_clk[g] = c;
    end

    freq_meter #(.N_CLK(N_CLK), .WINDOW(WINDOW), .DRAIN_CYC(DRAIN_CYC),
                 .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_freq_meter (
        .ref_clk(ref_clk), .rst_n(rst_n), .meas_clk(meas_clk), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int exp_count(int unsigned hp);
        longint c = (longint'(WINDOW) * REF_PS) / (2 * hp);
        return (c > CNT_MAX) ? CNT_MAX : int'(c);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_near(string req, int act, int exp);
        n_checks++;
        if (act > exp + TOL || act < exp - TOL) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d+-%0d", req, act, exp, TOL);
        end
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a);
        #0.5;
        d = reg_rdata;
    endtask

    // write at the next rising edge; returns 1 ns after it
    task automatic wr(int a, logic [31:0] d);
        @(negedge ref_clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(posedge ref_clk);
        #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do begin
            @(posedge ref_clk); #1;
            rd('h00, v);
        end while (v[0]);
    endtask

    task automatic check_lanes(string tag);
        logic [31:0] v;
        for (int i = 0; i < N_CLK; i++) begin
            rd('h10 + 4 * i, v);
            if (exp_count(hp_ps[i]) == CNT_MAX) chk({tag, " R7 lane saturates"}, v, CNT_MAX);
            else chk_near({tag, " R4 lane count"}, int'(v), exp_count(hp_ps[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge ref_clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N_CLK - 1; i++) hp_ps[i] = 1500 + 950 * i;
        hp_ps[N_CLK-1] = 1000;                       // 500 MHz -> saturates at 12 bits
        repeat (5) @(posedge ref_clk);
        #1 rst_n = 1'b1;
        @(posedge ref_clk); #1;

        // R1 reset state
        rd('h00, v); chk("R1 busy after reset", v, 0);
        rd('h04, v); chk("R1 ref count after reset", v, 0);
        rd('h10, v); chk("R1 lane0 after reset", v, 0);
        rd('h34, v); chk("R1 lane9 after reset", v, 0);

        // R9 unmapped offsets and stray writes
        rd('h08, v); chk("R9 read 0x08", v, 0);
        rd('h38, v); chk("R9 read 0x38", v, 0);
        wr('h08, 32'h1);
        rd('h00, v); chk("R9 write 0x08 no start", v, 0);
        wr('h04, 32'h1);
        rd('h00, v); chk("R9 write 0x04 no start", v, 0);

        // directed measurement with exact timing (R2, R3, R5)
        repeat (20) @(posedge ref_clk);
        wr('h00, 32'h1);                              // edge E0
        rd('h00, v); chk("R2 busy after start", v, 1);
        rd('h10, v); chk("R8 count zero while busy", v, 0);
        repeat (100) @(posedge ref_clk); #1;
        rd('h04, v); chk("R3 ref count mid window", v, 100);
        wr('h00, 32'h1);                              // E101, ignored
        rd('h04, v); chk("R5 start while busy ignored", v, 101);
        repeat (WINDOW + DRAIN_CYC - 1 - 101) @(posedge ref_clk); #1;
        rd('h00, v); chk("R2 busy at last busy cycle", v, 1);
        @(posedge ref_clk); #1;
        rd('h00, v); chk("R2 busy falls on time", v, 0);
        rd('h04, v); chk("R3 ref count at end", v, WINDOW);
        check_lanes("directed");

        // R8 hold
        rd('h10, held);
        repeat (57) @(posedge ref_clk); #1;
        wr('h20, 32'hFFFF_FFFF);
        rd('h10, v); chk("R8 count holds", v, held);

        // R6 clear during a run
        wr('h00, 32'h1);
        rd('h10, v); chk("R8 start zeroes counts", v, 0);
        repeat (300) @(posedge ref_clk); #1;
        wr('h00, 32'h8000_0000);
        rd('h00, v); chk("R6 clear drops busy", v, 0);
        rd('h04, v); chk("R6 clear zeroes ref count", v, 0);

        // R6 clear beats start in one write
        wr('h00, 32'h8000_0001);
        rd('h00, v); chk("R6 clear wins over start", v, 0);

        // measurement, then clear while idle
        wr('h00, 32'h1);
        wait_idle();
        rd('h34, v); chk("R7 lane9 saturated", v, CNT_MAX);
        wr('h00, 32'h8000_0000);
        rd('h34, v); chk("R6 idle clear lane9", v, 0);
        rd('h04, v); chk("R6 idle clear ref", v, 0);

        // constrained random periods
        for (int it = 0; it < 4; it++) begin
            for (int i = 0; i < N_CLK; i++) hp_ps[i] = $urandom_range(10000, 1300);
            repeat (30) @(posedge ref_clk);
            wr('h00, 32'h1);
            wait_idle();
            check_lanes("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule